// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Control Unit

This block is the sequencer and register set of a small accumulator machine. It runs every instruction as a series of clocked phases against a synchronous external memory: fetch, decode, operand address evaluation, operand read, execute and write-back. The registers are a program counter with an incrementer, an instruction register, a memory address register, a memory data register, an accumulator, one general register and a hidden temporary register that feeds the adder.

The memory port has a 16-bit address, 24-bit read and write data, and one-cycle read and write strobes. Memory returns read data on the cycle after the read strobe. Each memory word holds an 8-bit opcode in bits 23:16 and a 16-bit address in bits 15:0. Data values use bits 7:0.

The controller has eleven states:

| State | Work done in the cycle |
|-------|------------------------|
| FETCH_ADDR | program counter copied to the address register |
| FETCH_READ | read strobe |
| FETCH_CAPT | read word captured in the data register |
| LOAD_IR | data register copied to the instruction register |
| DECODE | opcode examined, counter stepped |
| EVAL_ADDR | operand address copied to the address register |
| OPND_READ | read strobe |
| OPND_CAPT | operand captured |
| EXECUTE | the instruction's register transfer |
| WRITEBACK | adder result stored, or write strobe |
| HALTED | terminal state |

The transitions are:
- The first four states follow one another unconditionally, and LOAD_IR leads to DECODE.
- DECODE goes to EVAL_ADDR for a load or a store, to EXECUTE for a move or an add, to HALTED for a halt, and back to FETCH_ADDR for any other opcode.
- EVAL_ADDR goes to OPND_READ for a load, and to EXECUTE for a store.
- OPND_READ leads to OPND_CAPT, which leads to EXECUTE.
- EXECUTE goes to WRITEBACK for an add or a store, and to FETCH_ADDR otherwise.
- WRITEBACK returns to FETCH_ADDR.
- HALTED stays in HALTED.

Top module: `acc_cpu_top`

## Requirements
- R1: Reset clears the program counter, accumulator, general register and both flags, deasserts halted and both strobes. The first fetch reads address 0.
- R2: Each instruction starts with a fetch that spans cycles 1 to 4. The read strobe is high in cycle 2 with the program counter on the address, the word is captured in cycle 3, and it is moved to the instruction register in cycle 4. A strobe is never high for two cycles in a row, and read and write are never high together.
- R3: The program counter steps by one in the decode cycle (cycle 5), after the instruction register has been loaded. Successive fetches therefore read consecutive addresses.
- R4: Opcode 0x4A (load) takes 9 cycles. Its address field goes to the address register in cycle 6, the read strobe is high in cycle 7, and bits 7:0 of the returned word are in the accumulator from the next instruction's first cycle onward.
- R5: Opcode 0x1D (move) takes 6 cycles. It copies the accumulator into the general register and raises no strobe after the fetch.
- R6: Opcode 0x46 (add) takes 7 cycles. The general register passes through the temporary register, and the 8-bit sum of the accumulator and the general register is written back to the accumulator.
- R7: Opcode 0x0E (store) takes 8 cycles. The write strobe is high in cycle 8, with the address field on the address and the accumulator on write data bits 7:0. Bits 23:8 of write data are zero.
- R8: Opcode 0x00 (halt) takes 5 cycles. The halted output is high from cycle 6 and stays high until reset. No strobe is raised and the counter does not move while halted.
- R9: Any other opcode is a no-op of 5 cycles. It leaves the accumulator, the general register and the flags unchanged.
- R10: Only an add updates the flags. Zero is set when the 8-bit sum is 0, and carry is set when the sum overflows 8 bits. All other instructions hold both flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| mem_addr | output | 16 | memory address, driven by the address register |
| mem_rd | output | 1 | read strobe, data returned next cycle |
| mem_wr | output | 1 | write strobe |
| mem_wdata | output | 24 | write data, driven by the data register |
| mem_rdata | input | 24 | read data |
| acc_out | output | 8 | accumulator |
| r0_out | output | 8 | general register |
| flag_z | output | 1 | zero flag |
| flag_c | output | 1 | carry flag |
| halted | output | 1 | high while the processor is stopped |

## Verification
The assertions check these properties on every cycle:
- The two strobes never overlap, and each strobe lasts a single cycle.
- A halted processor stays halted and is silent on the memory port.
- The flags move only in a cycle after the adder result was written.
- The upper write-data bits are zero.

The bench's reference model checks what only scenarios can show. It confirms the cycle on which each strobe falls, the addresses of successive fetches, the per-opcode cycle counts and the values the accumulator and the general register take. The program stores a sum and then loads it back, produces a sum that wraps with zero and carry set, and runs a move after that add to show that the move holds the flags. A second reset with a halt at address 0 shows that exactly one fetch occurs before the stop.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int OPC_W  = 8;
    localparam int WORD_W = OPC_W + ADDR_W;

    localparam logic [OPC_W-1:0] OP_HALT = 8'h00;
    localparam logic [OPC_W-1:0] OP_STA  = 8'h0E;
    localparam logic [OPC_W-1:0] OP_MOV  = 8'h1D;
    localparam logic [OPC_W-1:0] OP_ADD  = 8'h46;
    localparam logic [OPC_W-1:0] OP_LDA  = 8'h4A;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_FETCH_CAPT,
        ST_LOAD_IR,
        ST_DECODE,
        ST_EVAL_ADDR,
        ST_OPND_READ,
        ST_OPND_CAPT,
        ST_EXECUTE,
        ST_WRITEBACK,
        ST_HALTED
    } cpu_state_e;

    // register-transfer enables issued by the sequencer
    typedef struct packed {
        logic pc_to_mar;
        logic ir_to_mar;
        logic mem_rd;
        logic mem_wr;
        logic rd_to_mdr;
        logic mdr_to_ir;
        logic pc_inc;
        logic mdr_to_acc;
        logic acc_to_r0;
        logic r0_to_temp;
        logic alu_to_acc;
        logic acc_to_mdr;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             zero
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    // one full-adder cell per bit, carry rippling upward
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign sum[b]     = op_a[b] ^ op_b[b] ^ chain[b];
        assign chain[b+1] = (op_a[b] & op_b[b]) | (chain[b] & (op_a[b] ^ op_b[b]));
    end

    assign carry = chain[WIDTH];
    assign zero  = (sum == '0);

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int OPCODE_W = OPC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPCODE_W-1:0] opcode,
    output ctl_t                ctl,
    output logic                halted
);

    cpu_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH_ADDR;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_ADDR: state_nx = ST_FETCH_READ;
            ST_FETCH_READ: state_nx = ST_FETCH_CAPT;
            ST_FETCH_CAPT: state_nx = ST_LOAD_IR;
            ST_LOAD_IR:    state_nx = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_LDA || opcode == OP_STA) begin
                    state_nx = ST_EVAL_ADDR;
                end else if (opcode == OP_MOV || opcode == OP_ADD) begin
                    state_nx = ST_EXECUTE;
                end else if (opcode == OP_HALT) begin
                    state_nx = ST_HALTED;
                end else begin
                    state_nx = ST_FETCH_ADDR;
                end
            end
            ST_EVAL_ADDR:  state_nx = (opcode == OP_LDA) ? ST_OPND_READ : ST_EXECUTE;
            ST_OPND_READ:  state_nx = ST_OPND_CAPT;
            ST_OPND_CAPT:  state_nx = ST_EXECUTE;
            ST_EXECUTE: begin
                if (opcode == OP_ADD || opcode == OP_STA) begin
                    state_nx = ST_WRITEBACK;
                end else begin
                    state_nx = ST_FETCH_ADDR;
                end
            end
            ST_WRITEBACK:  state_nx = ST_FETCH_ADDR;
            ST_HALTED:     state_nx = ST_HALTED;
            default:       state_nx = ST_FETCH_ADDR;
        endcase
    end

    always_comb begin
        ctl    = '0;
        halted = 1'b0;
        unique case (state)
            ST_FETCH_ADDR: ctl.pc_to_mar = 1'b1;
            ST_FETCH_READ: ctl.mem_rd    = 1'b1;
            ST_FETCH_CAPT: ctl.rd_to_mdr = 1'b1;
            ST_LOAD_IR:    ctl.mdr_to_ir = 1'b1;
            ST_DECODE:     ctl.pc_inc    = (opcode != OP_HALT);
            ST_EVAL_ADDR:  ctl.ir_to_mar = 1'b1;
            ST_OPND_READ:  ctl.mem_rd    = 1'b1;
            ST_OPND_CAPT:  ctl.rd_to_mdr = 1'b1;
            ST_EXECUTE: begin
                ctl.mdr_to_acc = (opcode == OP_LDA);
                ctl.acc_to_r0  = (opcode == OP_MOV);
                ctl.r0_to_temp = (opcode == OP_ADD);
                ctl.acc_to_mdr = (opcode == OP_STA);
            end
            ST_WRITEBACK: begin
                ctl.alu_to_acc = (opcode == OP_ADD);
                ctl.mem_wr     = (opcode == OP_STA);
            end
            ST_HALTED:     halted = 1'b1;
            default:       ctl = '0;
        endcase
    end

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
    import acc_cpu_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int OW  = OPC_W,
    localparam int WW = OW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [WW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    output logic [OW-1:0] opcode,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] r0,
    output logic          flag_z,
    output logic          flag_c
);

    logic [AW-1:0] pc;
    logic [AW-1:0] mar;
    logic [WW-1:0] ir;
    logic [WW-1:0] mdr;
    logic [DW-1:0] temp;
    logic [DW-1:0] alu_sum;
    logic          alu_c;
    logic          alu_z;

    acc_cpu_alu #(.WIDTH(DW)) u_alu (
        .op_a  (acc),
        .op_b  (temp),
        .sum   (alu_sum),
        .carry (alu_c),
        .zero  (alu_z)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            mar    <= '0;
            ir     <= '0;
            mdr    <= '0;
            acc    <= '0;
            r0     <= '0;
            temp   <= '0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else begin
            if (ctl.pc_to_mar)  mar  <= pc;
            if (ctl.ir_to_mar)  mar  <= ir[AW-1:0];
            if (ctl.pc_inc)     pc   <= pc + 1'b1;
            if (ctl.rd_to_mdr)  mdr  <= mem_rdata;
            if (ctl.acc_to_mdr) mdr  <= {{(WW-DW){1'b0}}, acc};
            if (ctl.mdr_to_ir)  ir   <= mdr;
            if (ctl.mdr_to_acc) acc  <= mdr[DW-1:0];
            if (ctl.acc_to_r0)  r0   <= acc;
            if (ctl.r0_to_temp) temp <= r0;
            if (ctl.alu_to_acc) begin
                acc    <= alu_sum;
                flag_z <= alu_z;
                flag_c <= alu_c;
            end
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign opcode    = ir[WW-1:AW];

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
    import acc_cpu_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int OW  = OPC_W,
    localparam int WW = OW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [WW-1:0] mem_wdata,
    input  logic [WW-1:0] mem_rdata,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] r0_out,
    output logic          flag_z,
    output logic          flag_c,
    output logic          halted
);

    ctl_t          ctl;
    logic [OW-1:0] opcode;

    acc_cpu_ctrl #(.OPCODE_W(OW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .ctl    (ctl),
        .halted (halted)
    );

    acc_cpu_datapath #(.AW(AW), .DW(DW), .OW(OW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .acc       (acc_out),
        .r0        (r0_out),
        .flag_z    (flag_z),
        .flag_c    (flag_c)
    );

    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;

endmodule

// File: rtl/acc_cpu_checks.sv
module acc_cpu_checks #(
    parameter int WW = 24,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [WW-1:0] mem_wdata,
    input logic          halted,
    input logic          flag_z,
    input logic          flag_c,
    input logic          alu_wr
);

    // R2: strobes are exclusive
    a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: a read strobe lasts a single cycle
    a_r2_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R7: a write strobe lasts a single cycle and its upper data bits are zero
    a_r7_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    a_r7_wdata_upper: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata[WW-1:DW] == '0));

    // R8: a halted processor is silent and stays halted
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10: flags hold unless the adder result was written back
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_wr |=> $stable({flag_z, flag_c}));

endmodule

bind acc_cpu_top acc_cpu_checks #(.WW(WW), .DW(DW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .halted    (halted),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .alu_wr    (ctl.alu_to_acc)
);

// File: tb/acc_cpu_top_bench.sv
`timescale 1ns/1ps
module acc_cpu_top_bench;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic [7:0]  acc_out;
    logic [7:0]  r0_out;
    logic        flag_z;
    logic        flag_c;
    logic        halted;

    logic [23:0] mem [0:255];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int rd_seen = 0;

    // reference model state
    int          m_cyc;
    logic [15:0] m_pc;
    logic [23:0] m_ir;
    logic [7:0]  m_acc;
    logic [7:0]  m_r0;
    logic        m_z;
    logic        m_c;
    logic        m_halt;

    always #HALF clk = ~clk;

    acc_cpu_top u_acc_cpu_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc_out   (acc_out),
        .r0_out    (r0_out),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .halted    (halted)
    );

    // synchronous memory: read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int instr_len(input logic [7:0] op);
        case (op)
            8'h4A:   return 9;
            8'h0E:   return 8;
            8'h46:   return 7;
            8'h1D:   return 6;
            default: return 5;
        endcase
    endfunction

    // cycle-by-cycle model, compared against the ports away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            m_pc = '0; m_ir = '0; m_acc = '0; m_r0 = '0;
            m_z = 1'b0; m_c = 1'b0; m_halt = 1'b0;
            // the first edge with reset released completes cycle 1
            m_cyc = 2;
        end else begin
            logic [7:0] op;
            logic       e_rd;
            logic       e_wr;
            logic [15:0] e_addr;
            logic [8:0] s;
            op     = m_ir[23:16];
            e_rd   = !m_halt && (m_cyc == 2 || (op == 8'h4A && m_cyc == 7));
            e_wr   = !m_halt && op == 8'h0E && m_cyc == 8;
            e_addr = (m_cyc == 2) ? m_pc : m_ir[15:0];
            if (mem_rd) rd_seen++;
            check(mem_rd === e_rd, "R2 read strobe", 32'(mem_rd), 32'(e_rd));
            if (e_rd) check(mem_addr === e_addr, (m_cyc == 2) ? "R3 fetch address" : "R4 operand address",
                            32'(mem_addr), 32'(e_addr));
            check(mem_wr === e_wr, "R7 write strobe", 32'(mem_wr), 32'(e_wr));
            if (e_wr) begin
                check(mem_addr === m_ir[15:0], "R7 store address", 32'(mem_addr), 32'(m_ir[15:0]));
                check(mem_wdata === {16'h0, m_acc}, "R7 store data", 32'(mem_wdata), 32'({16'h0, m_acc}));
            end
            check(acc_out === m_acc, "R4 R6 R9 accumulator", 32'(acc_out), 32'(m_acc));
            check(r0_out === m_r0, "R5 R9 general register", 32'(r0_out), 32'(m_r0));
            check({flag_z, flag_c} === {m_z, m_c}, "R10 flags", 32'({flag_z, flag_c}), 32'({m_z, m_c}));
            check(halted === m_halt, "R8 halted", 32'(halted), 32'(m_halt));
            // advance
            if (!m_halt) begin
                if (m_cyc == 2) m_ir = mem[m_pc[7:0]];
                op = m_ir[23:16];
                if (m_cyc == 5) begin
                    if (op == 8'h00) m_halt = 1'b1;
                    else m_pc = m_pc + 16'd1;
                end
                if (!m_halt && m_cyc == instr_len(op)) begin
                    case (op)
                        8'h4A: m_acc = mem[m_ir[7:0]][7:0];
                        8'h1D: m_r0 = m_acc;
                        8'h46: begin
                            s = {1'b0, m_acc} + {1'b0, m_r0};
                            m_acc = s[7:0];
                            m_c = s[8];
                            m_z = (s[7:0] == 8'h00);
                        end
                        default: ;
                    endcase
                    m_cyc = 1;
                end else begin
                    m_cyc++;
                end
            end
        end
    end

    initial begin
        int base;
        for (int i = 0; i < 256; i++) mem[i] = 24'h0;
        mem[0]  = 24'h4AFFFC;  // load 02
        mem[1]  = 24'h1D0000;  // r0 = 02
        mem[2]  = 24'h4AFFFD;  // load 04
        mem[3]  = 24'h460000;  // acc = 06
        mem[4]  = 24'h0EFFFE;  // store 06
        mem[5]  = 24'h770000;  // unknown opcode
        mem[6]  = 24'h4AFFFE;  // load back 06
        mem[7]  = 24'h4AFFFB;  // load FA
        mem[8]  = 24'h1D0000;  // r0 = FA
        mem[9]  = 24'h4AFFFA;  // load 06
        mem[10] = 24'h460000;  // 06 + FA wraps to 00
        mem[11] = 24'h1D0000;  // r0 = 00, flags must hold
        mem[12] = 24'h4AFFF9;  // load 80
        mem[13] = 24'h460000;  // 80 + 00
        mem[14] = 24'h000000;  // halt
        mem[8'hF9] = 24'h000080;
        mem[8'hFA] = 24'h000006;
        mem[8'hFB] = 24'h0000FA;
        mem[8'hFC] = 24'h000002;
        mem[8'hFD] = 24'h000004;
        mem[8'hFE] = 24'h0000EE;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(!mem_rd && !mem_wr, "R1 strobes in reset", 32'({mem_rd, mem_wr}), 32'h0);
        check(acc_out == 8'h00 && r0_out == 8'h00, "R1 registers in reset",
              32'({acc_out, r0_out}), 32'h0);
        check(!flag_z && !flag_c && !halted, "R1 flags and halt in reset",
              32'({flag_z, flag_c, halted}), 32'h0);
        #1 rst_n = 1'b1;

        for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
        check(halted === 1'b1, "R8 program reaches halt", 32'(halted), 32'h1);
        check(mem[8'hFE] === 24'h000006, "R7 stored sum in memory", 32'(mem[8'hFE]), 32'h6);
        check(acc_out === 8'h80, "R6 final sum", 32'(acc_out), 32'h80);
        check(r0_out === 8'h00, "R5 final general register", 32'(r0_out), 32'h0);
        check({flag_z, flag_c} === 2'b00, "R10 flags after last add", 32'({flag_z, flag_c}), 32'h0);
        check(rd_seen == 21, "R2 R4 read strobe count", 32'(rd_seen), 32'd21);
        base = rd_seen;
        repeat (20) @(negedge clk);
        check(rd_seen == base && halted, "R8 no fetch while halted", 32'(rd_seen - base), 32'h0);

        // second run: halt at address 0 after a fresh reset
        #1 rst_n = 1'b0;
        mem[0] = 24'h000000;
        repeat (3) @(negedge clk);
        check(!halted && acc_out == 8'h00, "R1 reset clears halt and accumulator",
              32'({halted, acc_out}), 32'h0);
        base = rd_seen;
        #1 rst_n = 1'b1;
        repeat (12) @(negedge clk);
        check(halted === 1'b1, "R8 halt at first word", 32'(halted), 32'h1);
        check(rd_seen - base == 1, "R1 R8 single fetch before stop", 32'(rd_seen - base), 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog: actual running expected halted");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule